// File: doc/BRIEF.md
# Reset Handshake Responder

This block answers a byte-coded reset request on behalf of a memory sequencer. A requester writes codes onto an 8-bit command bus. The responder writes codes back onto an 8-bit status bus. While idle, the responder samples the command bus on every clock and waits for the request code 0x0F. When it accepts the request, it raises the status bus to 0x07 and pulses a start strobe to the local reset-and-calibration engine. It then waits for the engine's done strobe.

When the engine reports completion, the status bus moves to 0x08. It holds that value for as long as the command bus is anything other than 0x00. Once the requester clears the command bus, the status bus returns to 0x00 and the responder is idle again, ready for another request. The command bus is registered once on entry. A command change therefore reaches the status bus two rising edges after it is applied. A done strobe reaches the status bus on the next rising edge.

Top module: `rst_handshake_responder`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, status_o is 0x00 and cal_start_o is 0.
- R2: In idle, any command value other than exactly 0x0F (for example 0x0E, 0x10, 0xFF, 0x07) leaves status_o at 0x00 and produces no start pulse.
- R3: A command of 0x0F in idle drives status_o to 0x07 on the second rising edge after it is applied. In that same cycle cal_start_o is high, and it is high for exactly one cycle.
- R4: While the job runs, status_o holds 0x07. A command of 0x0F held or re-applied during the job produces no further start pulse.
- R5: A high cal_done_i while status_o is 0x07 changes status_o to 0x08 on the next rising edge.
- R6: status_o holds 0x08 while the registered command is non-zero, including 0x0F and arbitrary other values.
- R7: A command of 0x00 while status_o is 0x08 drives status_o to 0x00 on the second rising edge after it is applied. The block then serves a new 0x0F request again.
- R8: cal_done_i has no effect while idle or while status_o is 0x08.
- R9: status_o only ever carries one of 0x00, 0x07 or 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 8 | Command bus from the requester |
| status_o | output | 8 | Status bus to the requester |
| cal_start_o | output | 1 | One-cycle strobe that starts the reset-and-calibration job |
| cal_done_i | input | 1 | Completion strobe from the calibration engine |

## Verification
A wrong internal state surfaces on the status bus at the next rising edge, because status_o is a register loaded from the next state. A missing or duplicated start strobe is visible in the same cycle as the first 0x07. A state that fails to leave 0x08, or leaves it too early, shows within two edges of the command change, since the command passes through only one register stage. Each status transition is compared in order against the sequence the requester expects, so a skipped or repeated code is caught at the transition where it occurs.

// File: rtl/rhr_pkg.sv
package rhr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_REPORT = 2'd2
  } rhr_state_e;

endpackage

// File: rtl/rhr_reset_sync.sv
module rhr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rhr_cmd_sampler.sv
module rhr_cmd_sampler #(
  parameter int          CODE_W   = 8,
  parameter logic [7:0]  REQ_CODE = 8'h0F,
  parameter logic [7:0]  CLR_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cmd_i,
  output logic              req_hit_o,
  output logic              clr_hit_o
);

  localparam logic [CODE_W-1:0] REQ_W = CODE_W'(REQ_CODE);
  localparam logic [CODE_W-1:0] CLR_W = CODE_W'(CLR_CODE);

  logic [CODE_W-1:0] cmd_q;
  logic              smp_en;

  assign smp_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (smp_en) cmd_q <= cmd_i;
  end

  assign req_hit_o = (cmd_q == REQ_W);
  assign clr_hit_o = (cmd_q == CLR_W);

endmodule

// File: rtl/rhr_seq_fsm.sv
module rhr_seq_fsm
  import rhr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_hit_i,
  input  logic       clr_hit_i,
  input  logic       cal_done_i,
  output rhr_state_e state_o,
  output rhr_state_e next_o
);

  rhr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_hit_i)  state_d = ST_BUSY;
      ST_BUSY:   if (cal_done_i) state_d = ST_REPORT;
      ST_REPORT: if (clr_hit_i)  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign next_o  = state_d;

endmodule

// File: rtl/rhr_status_out.sv
module rhr_status_out
  import rhr_pkg::*;
#(
  parameter int         CODE_W    = 8,
  parameter logic [7:0] IDLE_CODE = 8'h00,
  parameter logic [7:0] ACK_CODE  = 8'h07,
  parameter logic [7:0] DONE_CODE = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rhr_state_e        state_i,
  input  rhr_state_e        next_i,
  output logic [CODE_W-1:0] status_o,
  output logic              start_o
);

  logic [CODE_W-1:0] status_d, status_q;
  logic              start_d, start_q;

  always_comb begin
    unique case (next_i)
      ST_BUSY:   status_d = CODE_W'(ACK_CODE);
      ST_REPORT: status_d = CODE_W'(DONE_CODE);
      default:   status_d = CODE_W'(IDLE_CODE);
    endcase
    start_d = (state_i == ST_IDLE) && (next_i == ST_BUSY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      start_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      start_q  <= start_d;
    end
  end

  assign status_o = status_q;
  assign start_o  = start_q;

endmodule

// File: rtl/rst_handshake_responder.sv
module rst_handshake_responder
  import rhr_pkg::*;
#(
  parameter int         CODE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REQ_CODE    = 8'h0F,
  parameter logic [7:0] ACK_CODE    = 8'h07,
  parameter logic [7:0] DONE_CODE   = 8'h08,
  parameter logic [7:0] IDLE_CODE   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cmd_i,
  output logic [CODE_W-1:0] status_o,
  output logic              cal_start_o,
  input  logic              cal_done_i
);

  logic       rst_int_n;
  logic       req_hit, clr_hit;
  rhr_state_e state_cur, state_nxt;

  rhr_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rhr_cmd_sampler #(
    .CODE_W   (CODE_W),
    .REQ_CODE (REQ_CODE),
    .CLR_CODE (IDLE_CODE)
  ) u_smp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_i     (cmd_i),
    .req_hit_o (req_hit),
    .clr_hit_o (clr_hit)
  );

  rhr_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_hit_i  (req_hit),
    .clr_hit_i  (clr_hit),
    .cal_done_i (cal_done_i),
    .state_o    (state_cur),
    .next_o     (state_nxt)
  );

  rhr_status_out #(
    .CODE_W    (CODE_W),
    .IDLE_CODE (IDLE_CODE),
    .ACK_CODE  (ACK_CODE),
    .DONE_CODE (DONE_CODE)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .state_i  (state_cur),
    .next_i   (state_nxt),
    .status_o (status_o),
    .start_o  (cal_start_o)
  );

endmodule

// File: rtl/rst_handshake_responder_chk.sv
module rst_handshake_responder_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cmd_i,
  input logic [CODE_W-1:0] status_o,
  input logic              cal_start_o,
  input logic              cal_done_i
);

  localparam logic [CODE_W-1:0] C_IDLE = CODE_W'(8'h00);
  localparam logic [CODE_W-1:0] C_ACK  = CODE_W'(8'h07);
  localparam logic [CODE_W-1:0] C_DONE = CODE_W'(8'h08);
  localparam logic [CODE_W-1:0] C_REQ  = CODE_W'(8'h0F);

  // R3: the start strobe coincides with the first cycle of the acknowledge code
  a_r3_start_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |-> (status_o == C_ACK) && ($past(status_o) == C_IDLE));

  // R3 and R4: the start strobe lasts a single cycle
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |=> !cal_start_o);

  // R2: the idle code is left only after the registered command showed the request code
  a_r2_idle_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == C_IDLE && $past(cmd_i) != C_REQ) |=> status_o == C_IDLE);

  // R4: the acknowledge code is held until done arrives
  a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == C_ACK && !cal_done_i) |=> status_o == C_ACK);

  // R5: done while acknowledging moves to the completion code
  a_r5_done_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == C_ACK && cal_done_i) |=> status_o == C_DONE);

  // R6: the completion code is held while the registered command is non-zero
  a_r6_report_held: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == C_DONE && $past(cmd_i) != C_IDLE) |=> status_o == C_DONE);

  // R7: a cleared command while reporting returns to the idle code
  a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == C_DONE && $past(cmd_i) == C_IDLE) |=> status_o == C_IDLE);

  // R9: only the three legal codes appear
  a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    status_o == C_IDLE || status_o == C_ACK || status_o == C_DONE);

endmodule

bind rst_handshake_responder rst_handshake_responder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_i       (cmd_i),
  .status_o    (status_o),
  .cal_start_o (cal_start_o),
  .cal_done_i  (cal_done_i)
);

// File: tb/rst_handshake_responder_tb_top.sv
module rst_handshake_responder_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] cmd_i;
  logic [7:0] status_o;
  logic       cal_start_o;
  logic       cal_done_i;

  int n_chk  = 0;
  int n_fail = 0;
  int n_start = 0;
  int cal_delay = 5;
  int cal_cnt = 0;
  bit manual_done = 0;
  bit finished = 0;
  logic [7:0] prev_status;
  logic [7:0] exp_q[$];

  rst_handshake_responder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .status_o    (status_o),
    .cal_start_o (cal_start_o),
    .cal_done_i  (cal_done_i)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // calibration engine model with a programmable delay
  always @(negedge clk) begin
    logic d;
    d = 1'b0;
    if (cal_start_o) cal_cnt = cal_delay;
    else if (cal_cnt > 0) begin
      cal_cnt--;
      if (cal_cnt == 0) d = 1'b1;
    end
    if (manual_done) begin
      d = 1'b1;
      manual_done = 0;
    end
    cal_done_i <= d;
  end

  // scoreboard monitor: every status change must match the next expected code
  always @(negedge clk) begin
    if (rst_n) begin
      if (cal_start_o) n_start++;
      if (status_o !== prev_status) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unexpected status change actual=%0h expected=none", status_o);
        end else begin
          check("R9 status sequence", status_o, exp_q.pop_front());
        end
      end
    end
    prev_status = status_o;
  end

  task automatic drive_cmd(logic [7:0] v, int cycles);
    @(negedge clk);
    cmd_i <= v;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(posedge clk);
    manual_done = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_status(logic [7:0] v, string req);
    int t = 0;
    while (status_o !== v && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(req, status_o, v);
  endtask

  task automatic handshake(int dly, string tag);
    int s0;
    cal_delay = dly;
    s0 = n_start;
    exp_q.push_back(8'h07);
    exp_q.push_back(8'h08);
    exp_q.push_back(8'h00);
    @(negedge clk);
    cmd_i <= 8'h0F;
    @(negedge clk);
    check({tag, " R3 not yet acked"}, status_o, 8'h00);
    @(negedge clk);
    check({tag, " R3 ack code"}, status_o, 8'h07);
    check({tag, " R3 start high"}, cal_start_o, 1'b1);
    @(negedge clk);
    check({tag, " R3 start one cycle"}, cal_start_o, 1'b0);
    check({tag, " R4 ack held"}, status_o, 8'h07);
    wait_status(8'h08, {tag, " R5 done code"});
    check({tag, " R4 single start"}, n_start - s0, 1);
    drive_cmd(8'h0F, 3);
    check({tag, " R6 held under 0x0F"}, status_o, 8'h08);
    drive_cmd(8'h33, 3);
    check({tag, " R6 held under 0x33"}, status_o, 8'h08);
    @(negedge clk);
    cmd_i <= 8'h00;
    @(negedge clk);
    check({tag, " R7 still reporting"}, status_o, 8'h08);
    @(negedge clk);
    check({tag, " R7 closed"}, status_o, 8'h00);
  endtask

  initial begin
    int s0;
    rst_n = 0;
    cmd_i = 8'h00;
    cal_done_i = 0;
    prev_status = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 status in reset", status_o, 8'h00);
    check("R1 start in reset", cal_start_o, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 status after reset", status_o, 8'h00);
    check("R1 start after reset", cal_start_o, 1'b0);

    // R2: near-miss commands in idle
    s0 = n_start;
    drive_cmd(8'h0E, 3);
    drive_cmd(8'h10, 3);
    drive_cmd(8'hFF, 3);
    drive_cmd(8'h07, 3);
    drive_cmd(8'h00, 3);
    check("R2 idle ignores non-request", status_o, 8'h00);
    check("R2 no start", n_start - s0, 0);

    // R8: done while idle
    pulse_done();
    @(negedge clk);
    check("R8 done in idle ignored", status_o, 8'h00);

    handshake(5, "H1");

    // R4: re-applied request during the job, R8: done while reporting
    cal_delay = 12;
    s0 = n_start;
    exp_q.push_back(8'h07);
    exp_q.push_back(8'h08);
    exp_q.push_back(8'h00);
    drive_cmd(8'h0F, 4);
    drive_cmd(8'h05, 2);
    drive_cmd(8'h0F, 3);
    check("R4 ack held over re-request", status_o, 8'h07);
    check("R4 no restart", n_start - s0, 1);
    wait_status(8'h08, "R5 done code second run");
    pulse_done();
    @(negedge clk);
    check("R8 done while reporting ignored", status_o, 8'h08);
    drive_cmd(8'h00, 3);
    check("R7 closed second run", status_o, 8'h00);

    // R7: a fresh request is served again with a short job
    handshake(1, "H3");

    repeat (5) @(negedge clk);
    check("R9 all expected codes seen", exp_q.size(), 0);
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule